// File: doc/BRIEF.md
# SDRAM Timing Parameter Converter

This block turns the timing bytes read from two memory modules into clock counts for a memory controller running at a given bus clock. It takes the row-active time, row-precharge time, activate-to-read/write delay, activate-to-activate delay, refresh-cycle time and refresh-rate code of each module, along with the bus clock in MHz. It combines the two modules by taking the worst case of each parameter and converts each nanosecond figure into whole memory clocks, always rounding up.

A conversion starts with a one-cycle `start` pulse. The block then works through the five nanosecond parameters one after another on a single multiplier and a bit-serial divider. Next it computes the refresh interval with the same multiplier, derives the row-cycle count, the refresh fallback and the write-to-read delay, and raises `done` for one cycle. Results stay on the outputs until the next conversion writes them.

Top module: `sdram_tconv`

## Requirements
- R1: Each module's timing byte reading 255 is taken as 0. For each parameter the larger of the two modules' values is used.
- R2: Row-active time and refresh-cycle time are in whole nanoseconds. Row-precharge, activate-to-command and activate-to-activate bytes are in quarter nanoseconds and are shifted right by two bits (floor) before conversion.
- R3: The memory clock is `bus_mhz` shifted right by one (floor). Each count is ceil(ns × memory MHz / 1000), taken modulo 256. This covers `act_pre_clk` (row-active), `pre_act_clk` (precharge), `act_cmd_clk` (activate-to-command) and `act_act_clk` (activate-to-activate).
- R4: `act_cycle_clk` equals bits [3:0] of `act_pre_clk` plus bits [2:0] of `pre_act_clk`.
- R5: `ref_act_clk` is the converted refresh-cycle time when the combined refresh-cycle byte is nonzero, and `act_cycle_clk` + 1 when it is zero.
- R6: `wr_rd_clk` is 2 when the memory clock is above 198 MHz and 1 otherwise.
- R7: A refresh code is the low nibble of its byte, clamped to 5. Codes 0..5 select periods of 15, 3, 7, 31, 62 and 125 µs. The shorter of the two modules' periods is used.
- R8: `ref_ivl` equals floor(period µs × memory MHz / 16).
- R9: `done` is high for exactly one cycle, no later than 104 cycles after the cycle in which `start` is sampled (default widths). A `start` pulse during a conversion is ignored: it neither restarts the conversion nor produces a second `done`. Outputs do not change while the block is idle.
- R10: After reset, `done` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (ignored while busy) |
| bus_mhz | input | BUS_W | Bus clock in MHz |
| ras_a | input | BYTE_W | Module A row-active time, ns |
| ras_b | input | BYTE_W | Module B row-active time, ns |
| rp_a | input | BYTE_W | Module A precharge time, quarter ns |
| rp_b | input | BYTE_W | Module B precharge time, quarter ns |
| rcd_a | input | BYTE_W | Module A activate-to-command, quarter ns |
| rcd_b | input | BYTE_W | Module B activate-to-command, quarter ns |
| rrd_a | input | BYTE_W | Module A activate-to-activate, quarter ns |
| rrd_b | input | BYTE_W | Module B activate-to-activate, quarter ns |
| rfc_a | input | BYTE_W | Module A refresh-cycle time, ns |
| rfc_b | input | BYTE_W | Module B refresh-cycle time, ns |
| ref_a | input | BYTE_W | Module A refresh-rate code byte |
| ref_b | input | BYTE_W | Module B refresh-rate code byte |
| done | output | 1 | One-cycle completion pulse |
| act_pre_clk | output | BYTE_W | Activate-to-precharge clocks |
| pre_act_clk | output | BYTE_W | Precharge-to-activate clocks |
| act_cmd_clk | output | BYTE_W | Activate-to-command clocks |
| act_act_clk | output | BYTE_W | Activate-to-activate clocks |
| act_cycle_clk | output | 5 | Activate-to-activate-or-refresh clocks |
| ref_act_clk | output | BYTE_W | Refresh-to-activate clocks |
| wr_rd_clk | output | 2 | Write-to-read delay |
| ref_ivl | output | BYTE_W+BUS_W-5 | Refresh interval count |

## Verification
The assertions assume that every timing byte and `bus_mhz` holds steady from the `start` pulse until `done`. The datapath reads them again for each parameter, and the fallback check relates the refresh-cycle inputs to the outputs at `done`. The bench sets up all inputs at least one cycle before it raises `start`. It changes them only after it has sampled the results, and its repeated mid-run `start` keeps the same input values.

// File: rtl/sdram_tconv_pkg.sv
package sdram_tconv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_WAIT,
        ST_REFR,
        ST_FIN
    } tconv_state_e;

    localparam int NPAR       = 5;     // ns parameters converted by the divider
    localparam int IDX_RAS    = 0;
    localparam int IDX_RP     = 1;
    localparam int IDX_RCD    = 2;
    localparam int IDX_RRD    = 3;
    localparam int IDX_RFC    = 4;
    localparam int CODE_MAX   = 5;
    localparam int PERIOD_W   = 7;
    localparam int WTR_LIMIT  = 198;

    // refresh period in microseconds for a clamped code
    function automatic logic [PERIOD_W-1:0] period_us(input logic [2:0] code);
        case (code)
            3'd0:    return 7'd15;
            3'd1:    return 7'd3;
            3'd2:    return 7'd7;
            3'd3:    return 7'd31;
            3'd4:    return 7'd62;
            default: return 7'd125;
        endcase
    endfunction

endpackage

// File: rtl/sdram_tconv_worst.sv
module sdram_tconv_worst #(
    parameter int W     = 8,
    parameter int SHIFT = 0
) (
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    output logic [W-1:0] worst
);
    logic [W-1:0] clean_a, clean_b, larger;

    always_comb begin
        clean_a = (val_a == '1) ? '0 : val_a;
        clean_b = (val_b == '1) ? '0 : val_b;
        larger  = (clean_a > clean_b) ? clean_a : clean_b;
        worst   = larger >> SHIFT;
    end
endmodule

// File: rtl/sdram_tconv_refresh.sv
module sdram_tconv_refresh
    import sdram_tconv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]        code_a,
    input  logic [W-1:0]        code_b,
    output logic [PERIOD_W-1:0] period
);
    logic [2:0]          sel_a, sel_b;
    logic [PERIOD_W-1:0] per_a, per_b;

    always_comb begin
        sel_a  = (code_a[3:0] > 4'(CODE_MAX)) ? 3'(CODE_MAX) : code_a[2:0];
        sel_b  = (code_b[3:0] > 4'(CODE_MAX)) ? 3'(CODE_MAX) : code_b[2:0];
        per_a  = period_us(sel_a);
        per_b  = period_us(sel_b);
        period = (per_a < per_b) ? per_a : per_b;
    end
endmodule

// File: rtl/sdram_tconv_div.sv
module sdram_tconv_div #(
    parameter int PW      = 17,
    parameter int DIVISOR = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [PW-1:0] dividend,
    output logic          fin,
    output logic [PW-1:0] quot_ceil
);
    localparam int RW = $clog2(DIVISOR) + 1;
    localparam int CW = $clog2(PW + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [PW-1:0] dvd;
        logic [RW-1:0] rem;
        logic [PW-1:0] quo;
        logic          fin;
    } div_t;

    div_t q, d;
    logic [RW-1:0] trial;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        trial = {q.rem[RW-2:0], q.dvd[PW-1]};
        if (!q.busy && go) begin
            d.busy = 1'b1;
            d.cnt  = CW'(PW);
            d.dvd  = dividend;
            d.rem  = '0;
            d.quo  = '0;
        end else if (q.busy) begin
            if (trial >= RW'(DIVISOR)) begin
                d.rem = trial - RW'(DIVISOR);
                d.quo = {q.quo[PW-2:0], 1'b1};
            end else begin
                d.rem = trial;
                d.quo = {q.quo[PW-2:0], 1'b0};
            end
            d.dvd = q.dvd << 1;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin       = q.fin;
    assign quot_ceil = q.quo + {{(PW-1){1'b0}}, |q.rem};
endmodule

// File: rtl/sdram_tconv.sv
module sdram_tconv
    import sdram_tconv_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int BUS_W   = 10,
    parameter int NS_DIV  = 1000,
    parameter int REF_SH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [BUS_W-1:0]             bus_mhz,
    input  logic [BYTE_W-1:0]            ras_a,
    input  logic [BYTE_W-1:0]            ras_b,
    input  logic [BYTE_W-1:0]            rp_a,
    input  logic [BYTE_W-1:0]            rp_b,
    input  logic [BYTE_W-1:0]            rcd_a,
    input  logic [BYTE_W-1:0]            rcd_b,
    input  logic [BYTE_W-1:0]            rrd_a,
    input  logic [BYTE_W-1:0]            rrd_b,
    input  logic [BYTE_W-1:0]            rfc_a,
    input  logic [BYTE_W-1:0]            rfc_b,
    input  logic [BYTE_W-1:0]            ref_a,
    input  logic [BYTE_W-1:0]            ref_b,
    output logic                         done,
    output logic [BYTE_W-1:0]            act_pre_clk,
    output logic [BYTE_W-1:0]            pre_act_clk,
    output logic [BYTE_W-1:0]            act_cmd_clk,
    output logic [BYTE_W-1:0]            act_act_clk,
    output logic [4:0]                   act_cycle_clk,
    output logic [BYTE_W-1:0]            ref_act_clk,
    output logic [1:0]                   wr_rd_clk,
    output logic [BYTE_W+BUS_W-6:0]      ref_ivl
);
    localparam int MEM_W = BUS_W - 1;
    localparam int PW    = BYTE_W + MEM_W;
    localparam int IVL_W = PW - REF_SH;
    localparam int IDX_W = $clog2(NPAR);
    localparam logic [NPAR-1:0] QUARTER_NS = 5'b01110;

    typedef struct packed {
        tconv_state_e                 st;
        logic [IDX_W-1:0]             idx;
        logic [MEM_W-1:0]             mem;
        logic [NPAR-1:0][BYTE_W-1:0]  res;
        logic [4:0]                   trc;
        logic [BYTE_W-1:0]            rfc;
        logic [1:0]                   wtr;
        logic [IVL_W-1:0]             ivl;
        logic                         done;
    } ctl_t;

    ctl_t q, d;

    logic [NPAR-1:0][BYTE_W-1:0] raw_a, raw_b, combined;
    logic [PERIOD_W-1:0]         period;
    logic [BYTE_W-1:0]           mul_a;
    logic [PW-1:0]               product;
    logic                        div_go, div_fin;
    logic [PW-1:0]               div_res;
    logic [4:0]                  trc_n;

    assign raw_a = {rfc_a, rrd_a, rcd_a, rp_a, ras_a};
    assign raw_b = {rfc_b, rrd_b, rcd_b, rp_b, ras_b};

    for (genvar i = 0; i < NPAR; i++) begin : g_worst
        sdram_tconv_worst #(
            .W     (BYTE_W),
            .SHIFT (QUARTER_NS[i] ? 2 : 0)
        ) u_worst (
            .val_a (raw_a[i]),
            .val_b (raw_b[i]),
            .worst (combined[i])
        );
    end

    sdram_tconv_refresh #(.W(BYTE_W)) u_refresh (
        .code_a (ref_a),
        .code_b (ref_b),
        .period (period)
    );

    // one multiplier shared by the ns conversions and the refresh interval
    assign mul_a   = (q.st == ST_REFR) ? BYTE_W'(period) : combined[q.idx];
    assign product = PW'(mul_a) * PW'(q.mem);
    assign div_go  = (q.st == ST_MUL);

    sdram_tconv_div #(.PW(PW), .DIVISOR(NS_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (div_go),
        .dividend  (product),
        .fin       (div_fin),
        .quot_ceil (div_res)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trc_n  = {1'b0, q.res[IDX_RAS][3:0]} + {2'b00, q.res[IDX_RP][2:0]};
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.mem = bus_mhz[BUS_W-1:1];
                    d.idx = '0;
                    d.st  = ST_MUL;
                end
            end
            ST_MUL: d.st = ST_WAIT;
            ST_WAIT: begin
                if (div_fin) begin
                    d.res[q.idx] = div_res[BYTE_W-1:0];
                    if (q.idx == IDX_W'(NPAR - 1)) begin
                        d.st = ST_REFR;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_MUL;
                    end
                end
            end
            ST_REFR: begin
                d.ivl = product[PW-1:REF_SH];
                d.st  = ST_FIN;
            end
            ST_FIN: begin
                d.trc  = trc_n;
                d.rfc  = (combined[IDX_RFC] == '0) ? BYTE_W'(trc_n) + BYTE_W'(1)
                                                    : q.res[IDX_RFC];
                d.wtr  = (int'(q.mem) > WTR_LIMIT) ? 2'd2 : 2'd1;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done          = q.done;
    assign act_pre_clk   = q.res[IDX_RAS];
    assign pre_act_clk   = q.res[IDX_RP];
    assign act_cmd_clk   = q.res[IDX_RCD];
    assign act_act_clk   = q.res[IDX_RRD];
    assign act_cycle_clk = q.trc;
    assign ref_act_clk   = q.rfc;
    assign wr_rd_clk     = q.wtr;
    assign ref_ivl       = q.ivl;
endmodule

// File: rtl/sdram_tconv_chk.sv
module sdram_tconv_chk #(
    parameter int BYTE_W = 8,
    parameter int BUS_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    done,
    input logic [BYTE_W-1:0]       act_pre_clk,
    input logic [BYTE_W-1:0]       pre_act_clk,
    input logic [4:0]              act_cycle_clk,
    input logic [BYTE_W-1:0]       ref_act_clk,
    input logic [1:0]              wr_rd_clk,
    input logic [BYTE_W-1:0]       rfc_a,
    input logic [BYTE_W-1:0]       rfc_b,
    input logic [BYTE_W+BUS_W-6:0] ref_ivl
);
    localparam int PW      = BYTE_W + BUS_W - 1;
    localparam int MAX_LAT = 5 * (PW + 3) + 4;
    localparam int LW      = $clog2(MAX_LAT + 2) + 1;

    logic          run_q;
    logic [LW-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            lat_q <= '0;
        end else if (start && (!run_q || done)) begin
            run_q <= 1'b1;
            lat_q <= '0;
        end else if (done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (int'(lat_q) <= MAX_LAT));

    p_done_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_q);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start) |=> ($stable(act_pre_clk) && $stable(ref_ivl)
                                && $stable(act_cycle_clk) && $stable(ref_act_clk)));

    p_trc_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (act_cycle_clk == {1'b0, act_pre_clk[3:0]} + {2'b00, pre_act_clk[2:0]}));

    p_rfc_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rfc_a == '0 || rfc_a == '1) && (rfc_b == '0 || rfc_b == '1))
        |-> (ref_act_clk == BYTE_W'(act_cycle_clk) + BYTE_W'(1)));

    p_wtr_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_rd_clk == 2'd1 || wr_rd_clk == 2'd2));
endmodule

bind sdram_tconv sdram_tconv_chk #(.BYTE_W(BYTE_W), .BUS_W(BUS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .done          (done),
    .act_pre_clk   (act_pre_clk),
    .pre_act_clk   (pre_act_clk),
    .act_cycle_clk (act_cycle_clk),
    .ref_act_clk   (ref_act_clk),
    .wr_rd_clk     (wr_rd_clk),
    .rfc_a         (rfc_a),
    .rfc_b         (rfc_b),
    .ref_ivl       (ref_ivl)
);

// File: tb/tb_sdram_tconv.sv
module tb_sdram_tconv;
    localparam int BYTE_W  = 8;
    localparam int BUS_W   = 10;
    localparam int IVL_W   = BYTE_W + BUS_W - 5;
    localparam int MAX_LAT = 104;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, start;
    logic [BUS_W-1:0]  bus_mhz;
    logic [BYTE_W-1:0] ras_a, ras_b, rp_a, rp_b, rcd_a, rcd_b;
    logic [BYTE_W-1:0] rrd_a, rrd_b, rfc_a, rfc_b, ref_a, ref_b;
    logic              done;
    logic [BYTE_W-1:0] act_pre_clk, pre_act_clk, act_cmd_clk, act_act_clk, ref_act_clk;
    logic [4:0]        act_cycle_clk;
    logic [1:0]        wr_rd_clk;
    logic [IVL_W-1:0]  ref_ivl;

    sdram_tconv dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz),
        .ras_a(ras_a), .ras_b(ras_b), .rp_a(rp_a), .rp_b(rp_b),
        .rcd_a(rcd_a), .rcd_b(rcd_b), .rrd_a(rrd_a), .rrd_b(rrd_b),
        .rfc_a(rfc_a), .rfc_b(rfc_b), .ref_a(ref_a), .ref_b(ref_b),
        .done(done), .act_pre_clk(act_pre_clk), .pre_act_clk(pre_act_clk),
        .act_cmd_clk(act_cmd_clk), .act_act_clk(act_act_clk),
        .act_cycle_clk(act_cycle_clk), .ref_act_clk(ref_act_clk),
        .wr_rd_clk(wr_rd_clk), .ref_ivl(ref_ivl)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h2545_f491;

    function automatic int san(int v);
        return (v == 255) ? 0 : v;
    endfunction

    function automatic int worst(int a, int b);
        return (san(a) > san(b)) ? san(a) : san(b);
    endfunction

    function automatic int conv(int ns, int mem);
        return ((ns * mem + 999) / 1000) % 256;
    endfunction

    function automatic int per(int raw);
        int c = raw & 15;
        if (c > 5) c = 5;
        case (c)
            0: return 15;
            1: return 3;
            2: return 7;
            3: return 31;
            4: return 62;
            default: return 125;
        endcase
    endfunction

    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // pulse start (optionally a second one mid-run), wait for done, compare
    task automatic run_case(bit extra_start);
        int mem, e_ras, e_rp, e_rcd, e_rrd, e_rfc_ns, e_trc, e_rfc, e_wtr, e_per, lat;
        mem      = int'(bus_mhz) / 2;
        e_ras    = conv(worst(ras_a, ras_b), mem);            // R1 R2 R3
        e_rp     = conv(worst(rp_a, rp_b) >> 2, mem);
        e_rcd    = conv(worst(rcd_a, rcd_b) >> 2, mem);
        e_rrd    = conv(worst(rrd_a, rrd_b) >> 2, mem);
        e_rfc_ns = worst(rfc_a, rfc_b);
        e_trc    = (e_ras & 15) + (e_rp & 7);
        e_rfc    = (e_rfc_ns == 0) ? e_trc + 1 : conv(e_rfc_ns, mem);
        e_wtr    = (mem > 198) ? 2 : 1;
        e_per    = (per(ref_a) < per(ref_b)) ? per(ref_a) : per(ref_b);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 1;
        while (!done && lat < MAX_LAT + 20) begin
            @(negedge clk);
            lat++;
            if (extra_start && lat == 10) start = 1'b1;
            else start = 1'b0;
        end
        chk("R9", "latency bound", int'(lat <= MAX_LAT), 1);
        chk("R3", "act_pre_clk", int'(act_pre_clk), e_ras);
        chk("R2", "pre_act_clk", int'(pre_act_clk), e_rp);
        chk("R2", "act_cmd_clk", int'(act_cmd_clk), e_rcd);
        chk("R1", "act_act_clk", int'(act_act_clk), e_rrd);
        chk("R4", "act_cycle_clk", int'(act_cycle_clk), e_trc);
        chk("R5", "ref_act_clk", int'(ref_act_clk), e_rfc);
        chk("R6", "wr_rd_clk", int'(wr_rd_clk), e_wtr);
        chk("R8", "ref_ivl", int'(ref_ivl), (e_per * mem) / 16);
        @(negedge clk);
        chk("R9", "done one cycle", int'(done), 0);
    endtask

    function automatic logic [7:0] pick(logic [31:0] r);
        case (r[10:8])
            3'd0:    return 8'hFF;
            3'd1:    return 8'h00;
            default: return r[7:0];
        endcase
    endfunction

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int buses[10] = '{0, 3, 100, 266, 396, 397, 398, 399, 533, 1023};
        rst_n = 1'b0; start = 1'b0; bus_mhz = '0;
        {ras_a, ras_b, rp_a, rp_b, rcd_a, rcd_b} = '0;
        {rrd_a, rrd_b, rfc_a, rfc_b, ref_a, ref_b} = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "done", int'(done), 0);
        chk("R10", "act_pre_clk", int'(act_pre_clk), 0);
        chk("R10", "act_cycle_clk", int'(act_cycle_clk), 0);
        chk("R10", "ref_act_clk", int'(ref_act_clk), 0);
        chk("R10", "wr_rd_clk", int'(wr_rd_clk), 0);
        chk("R10", "ref_ivl", int'(ref_ivl), 0);
        @(negedge clk) rst_n = 1'b1;

        // R1..R6, R8: bus clock sweep with mixed absent/zero/random bytes
        foreach (buses[b]) begin
            for (int k = 0; k < 40; k++) begin
                bus_mhz = BUS_W'(buses[b]);
                seed = nxt(seed); ras_a = pick(seed);
                seed = nxt(seed); ras_b = pick(seed);
                seed = nxt(seed); rp_a  = pick(seed);
                seed = nxt(seed); rp_b  = pick(seed);
                seed = nxt(seed); rcd_a = pick(seed);
                seed = nxt(seed); rcd_b = pick(seed);
                seed = nxt(seed); rrd_a = pick(seed);
                seed = nxt(seed); rrd_b = pick(seed);
                seed = nxt(seed); rfc_a = pick(seed);
                seed = nxt(seed); rfc_b = pick(seed);
                seed = nxt(seed); ref_a = seed[7:0];
                seed = nxt(seed); ref_b = seed[7:0];
                run_case(1'b0);
            end
        end

        // R7, R8: every pair of refresh nibbles
        bus_mhz = 10'd400;
        for (int ca = 0; ca < 16; ca++) begin
            for (int cb = 0; cb < 16; cb++) begin
                ref_a = 8'(ca) | 8'hA0;
                ref_b = 8'(cb) | 8'h50;
                run_case(1'b0);
            end
        end

        // R9: start while busy is ignored, no second done follows
        bus_mhz = 10'd266; ras_a = 8'd45; ras_b = 8'd40; rp_a = 8'd80; rp_b = 8'hFF;
        rfc_a = 8'd0; rfc_b = 8'hFF;
        run_case(1'b1);
        begin
            int extra = 0;
            for (int c = 0; c < MAX_LAT + 20; c++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R9", "no extra done after busy start", extra, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule